// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches three external interrupt pins on behalf of a small processor core and turns their activity into request lines for the core's interrupt arbiter. Each pin is brought into the clock domain through a flop synchroniser. A detector then compares successive synchronised samples against the condition that software has configured for that pin. Pins 0 and 1 each accept four sense modes, one of them a pure level mode. Pin 2 only detects edges, and a single bit selects its polarity.

A detected edge condition latches a per-pin pending flag. The flag stays set until software writes a one to it, or until the core acknowledges that interrupt on entry to its service routine. A request line is raised only while both the core's global interrupt-enable input and the pin's own enable bit are high. In level mode no flag is latched: the request simply follows the synchronised low level of the pin. The block always observes the pad level, so a pin driven by its own output driver still triggers.

Software reaches three byte-wide registers through a small register interface. Writes take effect on the clock edge and reads are combinational.

Top module: `ext_irq_sense`

## Requirements
- R1: The control register (address 0) holds the pin 0 sense field in bits 1:0 and the pin 1 sense field in bits 3:2. Sense value 00 requests while the pin is low, 01 flags any change of level, 10 flags a falling edge and 11 flags a rising edge. Edges that do not match the selected mode leave the flag clear.
- R2: Pin 2 detects edges only. Its polarity bit is bit 4 of the control register: 0 flags a falling edge and 1 flags a rising edge. Bits 7:5 of the control register read as zero.
- R3: `irq_o[n]` is high only while `global_ie_i` is 1 and pin n's enable bit is 1. A pending flag with either of these low produces no request.
- R4: The enable register (address 1) has the pin 1 enable at bit 7, the pin 0 enable at bit 6 and the pin 2 enable at bit 5. Bits 4:2 read as zero. Bit 1 is the vector-select bit and drives `vec_sel_o`. Bit 0 is a stored change-enable bit.
- R5: The flag register (address 2) has the pin 1 flag at bit 7, the pin 0 flag at bit 6 and the pin 2 flag at bit 5, and its other bits read as zero. A flag sets on its detected condition even while that pin is disabled. Address 3 reads as zero.
- R6: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R7: An acknowledge pulse on `ack_i[n]` clears pin n's flag.
- R8: If a detected condition and a clear (by write or by acknowledge) fall on the same clock edge, the flag ends up set.
- R9: A pin change applied before clock edge k shows in the flag register after edge k+2. A pulse held for two clock cycles is flagged.
- R10: In low-level mode `irq_o[n]` is high from the second edge after the pin goes low until the second edge after it returns high, and no flag is latched.
- R11: After reset all registers and flags read 0 and all request lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 3 | Pad levels; bit n is pin n |
| global_ie_i | input | 1 | Core's global interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 control, 1 enable, 2 flags) |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| ack_i | input | 3 | Service-entry acknowledge; bit n is pin n |
| irq_o | output | 3 | Request lines to the arbiter; bit n is pin n |
| vec_sel_o | output | 1 | Vector-select bit from the enable register |

## Verification
The bench targets the three-edge latency from pin to flag. A design with one synchroniser stage too many or too few reports the flag a cycle late or early, and a two-cycle pulse exposes it. It hits a detected condition and a write-one-to-clear on the same edge: a design that lets the clear win loses the interrupt. It also checks edges that oppose the selected polarity, which a wrongly decoded sense field or polarity bit would flag. Finally, it runs level mode, where a design that latches a flag keeps requesting after the pin returns high, and gates requests with each enable alone, which an incomplete AND term would let through.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   localparam int unsigned PIN_COUNT = 3;
   localparam int unsigned REG_W     = 8;

   // register addresses
   localparam int unsigned ADDR_CTL  = 0;
   localparam int unsigned ADDR_EN   = 1;
   localparam int unsigned ADDR_FLG  = 2;

   // bit positions shared by the enable and flag registers
   localparam int unsigned POS_PIN0  = 6;
   localparam int unsigned POS_PIN1  = 7;
   localparam int unsigned POS_PIN2  = 5;
   localparam int unsigned POS_VSEL  = 1;
   localparam int unsigned POS_VCE   = 0;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   function automatic int unsigned pin_pos(input int unsigned pin);
      case (pin)
         0:       return POS_PIN0;
         1:       return POS_PIN1;
         default: return POS_PIN2;
      endcase
   endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
   parameter int unsigned STAGES    = 2,
   parameter int unsigned WIDTH     = 3,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("eis_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= {WIDTH{RESET_VAL}};
         end else if (s == 0) begin
            chain_q[s] <= async_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/eis_detect.sv
module eis_detect #(
   parameter bit   LEVEL_CAPABLE = 1'b1,
   parameter logic IDLE_LEVEL    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl_i,
   input  logic [1:0] mode_i,
   output logic       event_o,
   output logic       low_req_o
);
   import ext_irq_pkg::*;

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LEVEL;
      else        prev_q <= lvl_i;
   end

   logic fell, rose;
   assign fell =  prev_q & ~lvl_i;
   assign rose = ~prev_q &  lvl_i;

   if (LEVEL_CAPABLE) begin : g_full
      sense_e mode;
      assign mode = sense_e'(mode_i);

      always_comb begin
         unique case (mode)
            SENSE_LOW:  event_o = 1'b0;
            SENSE_ANY:  event_o = fell | rose;
            SENSE_FALL: event_o = fell;
            default:    event_o = rose;
         endcase
      end

      assign low_req_o = (mode == SENSE_LOW) & ~lvl_i;
   end else begin : g_edge_only
      // only the polarity bit matters on an edge-only channel
      logic unused_hi;
      assign unused_hi = mode_i[1];
      assign event_o   = mode_i[0] ? rose : fell;
      assign low_req_o = 1'b0;
   end

endmodule

// File: rtl/eis_regs.sv
module eis_regs #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned NPINS  = 3,
   parameter int unsigned DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     rdata_o,
   input  logic [NPINS-1:0]  set_i,
   input  logic [NPINS-1:0]  ack_i,
   output logic [1:0]        sense0_o,
   output logic [1:0]        sense1_o,
   output logic              pol2_o,
   output logic [NPINS-1:0]  en_o,
   output logic [NPINS-1:0]  flag_o,
   output logic              vsel_o
);
   import ext_irq_pkg::*;

   localparam int unsigned CTL_USED = 5;

   if (DW < 8) begin : g_bad_dw
      $error("eis_regs: register width must be at least 8");
   end
   if (NPINS != 3) begin : g_bad_pins
      $error("eis_regs: layout fixed at three pins");
   end

   logic [CTL_USED-1:0] ctl_q;
   logic [NPINS-1:0]    en_q;
   logic [NPINS-1:0]    flag_q;
   logic                vsel_q, vce_q;

   logic wr_ctl, wr_en, wr_flg;
   assign wr_ctl = wr_en_i && (addr_i == ADDR_W'(ADDR_CTL));
   assign wr_en  = wr_en_i && (addr_i == ADDR_W'(ADDR_EN));
   assign wr_flg = wr_en_i && (addr_i == ADDR_W'(ADDR_FLG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         vsel_q <= 1'b0;
         vce_q  <= 1'b0;
      end else begin
         if (wr_ctl) ctl_q <= wdata_i[CTL_USED-1:0];
         if (wr_en) begin
            vsel_q <= wdata_i[POS_VSEL];
            vce_q  <= wdata_i[POS_VCE];
         end
      end
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      localparam int unsigned POS = pin_pos(p);
      logic clr;
      assign clr = (wr_flg && wdata_i[POS]) || ack_i[p];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[p]   <= 1'b0;
            flag_q[p] <= 1'b0;
         end else begin
            if (wr_en) en_q[p] <= wdata_i[POS];
            // a new event outranks a simultaneous clear
            if (set_i[p])  flag_q[p] <= 1'b1;
            else if (clr)  flag_q[p] <= 1'b0;
         end
      end
   end

   logic [DW-1:0] en_byte, flg_byte;
   always_comb begin
      en_byte  = '0;
      flg_byte = '0;
      for (int p = 0; p < NPINS; p++) begin
         en_byte[pin_pos(p)]  = en_q[p];
         flg_byte[pin_pos(p)] = flag_q[p];
      end
      en_byte[POS_VSEL] = vsel_q;
      en_byte[POS_VCE]  = vce_q;
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(ADDR_CTL))      rdata_o[CTL_USED-1:0] = ctl_q;
      else if (addr_i == ADDR_W'(ADDR_EN))  rdata_o = en_byte;
      else if (addr_i == ADDR_W'(ADDR_FLG)) rdata_o = flg_byte;
   end

   assign sense0_o = ctl_q[1:0];
   assign sense1_o = ctl_q[3:2];
   assign pol2_o   = ctl_q[4];
   assign en_o     = en_q;
   assign flag_o   = flag_q;
   assign vsel_o   = vsel_q;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 2,
   parameter logic        IDLE_LEVEL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        pin_i,
   input  logic              global_ie_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   input  logic [2:0]        ack_i,
   output logic [2:0]        irq_o,
   output logic              vec_sel_o
);
   import ext_irq_pkg::*;

   localparam int unsigned NP = PIN_COUNT;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ext_irq_sense: ADDR_W must cover three registers");
   end

   logic [NP-1:0] sync_lvl;
   logic [NP-1:0] set_ev;
   logic [NP-1:0] low_req;
   logic [NP-1:0] en_q;
   logic [NP-1:0] flag_q;
   logic [1:0]    sense0, sense1;
   logic          pol2;
   logic [1:0]    mode_vec [NP];

   eis_sync #(
      .STAGES    (SYNC_STAGES),
      .WIDTH     (NP),
      .RESET_VAL (IDLE_LEVEL)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_i),
      .sync_o  (sync_lvl)
   );

   assign mode_vec[0] = sense0;
   assign mode_vec[1] = sense1;
   assign mode_vec[2] = {1'b1, pol2};

   for (genvar p = 0; p < NP; p++) begin : g_det
      eis_detect #(
         .LEVEL_CAPABLE (p < 2),
         .IDLE_LEVEL    (IDLE_LEVEL)
      ) u_det (
         .clk       (clk),
         .rst_n     (rst_n),
         .lvl_i     (sync_lvl[p]),
         .mode_i    (mode_vec[p]),
         .event_o   (set_ev[p]),
         .low_req_o (low_req[p])
      );
   end

   eis_regs #(
      .ADDR_W (ADDR_W),
      .NPINS  (NP),
      .DW     (REG_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en_i),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .rdata_o  (rdata_o),
      .set_i    (set_ev),
      .ack_i    (ack_i),
      .sense0_o (sense0),
      .sense1_o (sense1),
      .pol2_o   (pol2),
      .en_o     (en_q),
      .flag_o   (flag_q),
      .vsel_o   (vec_sel_o)
   );

   assign irq_o = (flag_q | low_req) & en_q & {NP{global_ie_i}};

endmodule

// File: rtl/eis_chk.sv
module eis_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       global_ie_i,
   input logic       wr_en_i,
   input logic [1:0] addr_i,
   input logic [7:0] wdata_i,
   input logic [7:0] rdata_o,
   input logic [2:0] ack_i,
   input logic [2:0] irq_o,
   input logic [2:0] set_ev,
   input logic [2:0] flag_q,
   input logic [2:0] sync_lvl
);
   import ext_irq_pkg::*;

   // R3
   gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !global_ie_i |-> (irq_o == 3'b000));

   // R5
   flag_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == 2'(ADDR_FLG)) |-> (rdata_o[4:0] == 5'b0));

   for (genvar p = 0; p < 3; p++) begin : g_pin
      localparam int unsigned POS = pin_pos(p);

      // R8
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_ev[p] |=> flag_q[p]);

      // R7
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i[p] && !set_ev[p]) |=> !flag_q[p]);

      // R6
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i && addr_i == 2'(ADDR_FLG) && wdata_i[POS] && !set_ev[p])
         |=> !flag_q[p]);

      // R10
      high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sync_lvl[p] && !flag_q[p]) |-> !irq_o[p]);
   end

endmodule

bind ext_irq_sense eis_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .global_ie_i (global_ie_i),
   .wr_en_i     (wr_en_i),
   .addr_i      (addr_i),
   .wdata_i     (wdata_i),
   .rdata_o     (rdata_o),
   .ack_i       (ack_i),
   .irq_o       (irq_o),
   .set_ev      (set_ev),
   .flag_q      (flag_q),
   .sync_lvl    (sync_lvl)
);

// File: tb/ext_irq_sense_tb.sv
`timescale 1ns/1ps
module ext_irq_sense_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] pin_i = 3'b111;
   logic       global_ie_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [1:0] addr_i = 2'd0;
   logic [7:0] wdata_i = 8'h00;
   logic [7:0] rdata_o;
   logic [2:0] ack_i = 3'b000;
   logic [2:0] irq_o;
   logic       vec_sel_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ext_irq_sense u_dut (
      .clk (clk), .rst_n (rst_n), .pin_i (pin_i), .global_ie_i (global_ie_i),
      .wr_en_i (wr_en_i), .addr_i (addr_i), .wdata_i (wdata_i),
      .rdata_o (rdata_o), .ack_i (ack_i), .irq_o (irq_o),
      .vec_sel_o (vec_sel_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [2:0] hist[$];
   int  m_sense[3];
   int  m_en[3];
   int  m_flag[3];
   int  m_vsel, m_vce;

   function automatic int bitpos(input int p);
      return (p == 0) ? 6 : (p == 1) ? 7 : 5;
   endfunction

   function automatic int mode_of(input int p);
      return m_sense[p];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = {3'b111, 3'b111, 3'b111};
         for (int p = 0; p < 3; p++) begin
            m_sense[p] = 0; m_en[p] = 0; m_flag[p] = 0;
         end
         m_sense[2] = 2;
         m_vsel = 0; m_vce = 0;
      end else begin
         for (int p = 0; p < 3; p++) begin
            int now_l, old_l, ev, clr;
            now_l = hist[1][p];
            old_l = hist[2][p];
            case (mode_of(p))
               1:       ev = (now_l != old_l);
               2:       ev = (old_l == 1 && now_l == 0);
               3:       ev = (old_l == 0 && now_l == 1);
               default: ev = 0;
            endcase
            clr = (wr_en_i && addr_i == 2 && wdata_i[bitpos(p)]) || ack_i[p];
            if (ev != 0)       m_flag[p] = 1;
            else if (clr != 0) m_flag[p] = 0;
         end
         if (wr_en_i && addr_i == 0) begin
            m_sense[0] = wdata_i[1:0];
            m_sense[1] = wdata_i[3:2];
            m_sense[2] = wdata_i[4] ? 3 : 2;
         end
         if (wr_en_i && addr_i == 1) begin
            for (int p = 0; p < 3; p++) m_en[p] = wdata_i[bitpos(p)];
            m_vsel = wdata_i[1];
            m_vce  = wdata_i[0];
         end
         hist.push_front(pin_i);
         void'(hist.pop_back());
      end
   end

   function automatic logic [2:0] exp_irq();
      logic [2:0] r;
      for (int p = 0; p < 3; p++) begin
         int req;
         req = m_flag[p];
         if (p < 2 && m_sense[p] == 0 && hist[1][p] == 1'b0) req = 1;
         r[p] = (req != 0) && (m_en[p] != 0) && global_ie_i;
      end
      return r;
   endfunction

   function automatic logic [7:0] exp_rd();
      logic [7:0] r;
      r = 8'h00;
      case (addr_i)
         2'd0: r = {3'b000, (m_sense[2] == 3) ? 1'b1 : 1'b0,
                    2'(m_sense[1]), 2'(m_sense[0])};
         2'd1: begin
            for (int p = 0; p < 3; p++) r[bitpos(p)] = m_en[p][0];
            r[1] = m_vsel[0];
            r[0] = m_vce[0];
         end
         2'd2: for (int p = 0; p < 3; p++) r[bitpos(p)] = m_flag[p][0];
         default: r = 8'h00;
      endcase
      return r;
   endfunction

   // per-clock comparison, sampled 1 ns after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R3 R10 irq_o vs model", irq_o, exp_irq());
         chk("R4 R5 R6 rdata_o vs model", rdata_o, exp_rd());
         chk("R4 vec_sel_o vs model", vec_sel_o, m_vsel);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr_i = a;
      #0.5;
      d = rdata_o;
   endtask

   initial begin
      #1000000;
      chk("watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] d;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R11 reset state
      rd(2'd0, d); chk("R11 control after reset", d, 8'h00);
      rd(2'd1, d); chk("R11 enable after reset", d, 8'h00);
      rd(2'd2, d); chk("R11 flags after reset", d, 8'h00);
      chk("R11 irq after reset", irq_o, 0);
      rd(2'd3, d); chk("R5 unused address reads zero", d, 8'h00);

      global_ie_i = 1'b1;
      wr(2'd0, 8'h0E);            // pin0 falling, pin1 rising, pin2 falling
      wr(2'd1, 8'hE0);
      // R9 latency: pin0 falls before edge 1, flag after edge 3
      pin_i[0] = 1'b0;
      tick(2); rd(2'd2, d); chk("R9 flag not yet set after two edges", d, 8'h00);
      tick(1); rd(2'd2, d); chk("R9 flag set after third edge", d, 8'h40);
      chk("R3 irq raised for enabled pin0", irq_o, 3'b001);
      // R7 acknowledge clears
      ack_i[0] = 1'b1; tick(1); ack_i[0] = 1'b0;
      rd(2'd2, d); chk("R7 acknowledge cleared flag", d, 8'h00);
      // R1 falling mode ignores rising edge
      pin_i[0] = 1'b1; tick(4);
      rd(2'd2, d); chk("R1 falling mode ignores rise", d, 8'h00);
      // R1 rising mode on pin1
      pin_i[1] = 1'b0; tick(4);
      rd(2'd2, d); chk("R1 rising mode ignores fall", d, 8'h00);
      pin_i[1] = 1'b1; tick(3);
      rd(2'd2, d); chk("R1 rising mode flags rise", d, 8'h80);
      // R6 write-zero and write-one
      wr(2'd2, 8'h00);
      rd(2'd2, d); chk("R6 writing zero keeps flag", d, 8'h80);
      wr(2'd2, 8'h80);
      rd(2'd2, d); chk("R6 writing one clears flag", d, 8'h00);
      // R2 / R9 two-cycle pulse on pin2, falling polarity
      pin_i[2] = 1'b0; tick(2); pin_i[2] = 1'b1; tick(2);
      rd(2'd2, d); chk("R2 R9 short low pulse flagged", d, 8'h20);
      // R3 gating
      global_ie_i = 1'b0; #0.5; chk("R3 global enable low blocks", irq_o, 3'b000);
      global_ie_i = 1'b1; #0.5; chk("R3 global enable high passes", irq_o, 3'b100);
      wr(2'd1, 8'hC0);
      chk("R3 pin enable low blocks", irq_o, 3'b000);
      rd(2'd2, d); chk("R5 flag held while disabled", d, 8'h20);
      wr(2'd2, 8'h20);
      // R2 rising polarity on pin2
      wr(2'd0, 8'h1E);
      rd(2'd0, d); chk("R2 control readback", d, 8'h1E);
      pin_i[2] = 1'b0; tick(4);
      rd(2'd2, d); chk("R2 rising polarity ignores fall", d, 8'h00);
      pin_i[2] = 1'b1; tick(4);
      rd(2'd2, d); chk("R2 R5 rising polarity flags while disabled", d, 8'h20);
      chk("R3 disabled pin2 gives no request", irq_o, 3'b000);
      wr(2'd2, 8'h20);
      // R4 enable register layout
      wr(2'd1, 8'hFF);
      rd(2'd1, d); chk("R4 enable readback masks unused bits", d, 8'hE3);
      chk("R4 vector select output", vec_sel_o, 1);
      wr(2'd1, 8'hE0);
      chk("R4 vector select cleared", vec_sel_o, 0);
      // R8 set and clear on the same edge, pin0 any-change
      wr(2'd0, 8'h1D);
      pin_i[0] = 1'b0;
      tick(2);
      wr_en_i = 1'b1; addr_i = 2'd2; wdata_i = 8'h40;
      tick(1);
      wr_en_i = 1'b0;
      rd(2'd2, d); chk("R8 set wins over clear", d, 8'h40);
      wr(2'd2, 8'h40);
      pin_i[0] = 1'b1; tick(4);
      rd(2'd2, d); chk("R1 any-change flags rise", d, 8'h40);
      wr(2'd2, 8'h40);
      // R10 level mode on pin1
      wr(2'd0, 8'h11);
      pin_i[1] = 1'b0;
      tick(1); chk("R10 level request not yet up", irq_o[1], 0);
      tick(1); chk("R10 level request up", irq_o[1], 1);
      rd(2'd2, d); chk("R10 no flag in level mode", d, 8'h00);
      pin_i[1] = 1'b1;
      tick(1); chk("R10 level request still up", irq_o[1], 1);
      tick(1); chk("R10 level request dropped", irq_o[1], 0);
      tick(4);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule